// File: doc/BRIEF.md
# Dual-Clock Programmable Threshold Flag Generator

This block produces the two threshold flags of a dual-clock FIFO: an active-low "nearly empty" flag (`near_empty_n`) and an active-low "nearly full" flag (`near_full_n`). It does not hold the FIFO storage. It watches the binary write pointer, which is owned by the write clock, and the binary read pointer, which is owned by the read clock. Each pointer is carried into the opposite clock domain as gray code through a two-flop synchronizer. The block compares the word count and the free space against two offset registers that software can program.

A master reset samples two choices, and both are held until the next master reset.
- **Flag timing.** In split timing, each flag goes active on an edge of the clock that drives it towards its threshold. It goes inactive on an edge of the other clock. In single-clock timing, the nearly-empty flag is owned entirely by the read clock and the nearly-full flag entirely by the write clock.
- **Parallel offset layout.** With the parity layout selected, the offset-load word carries a parity bit at the top of each 9-bit lane, and those bits are skipped. With the plain layout, the low 32 bits are offset data.

The pointers are one bit wider than the address, so that a full FIFO can be told apart from an empty one. The offset registers are quasi-static: they are loaded from the write-clock side while the read side is idle.

Top module: `pflag_gen`

## Requirements
- R1: While `mrst_n` is low, at each clock edge, `near_empty_n` reads 0 and `near_full_n` reads 1. Both offsets return to the default value `DEF_OFS` (7).
- R2: Once pointers and offsets have been stable for 8 cycles of each clock, `near_empty_n` is 0 exactly when the count (`wr_ptr - rd_ptr` modulo 2^(AW+1)) is at or below the empty offset.
- R3: Once inputs have been stable for 8 cycles of each clock, `near_full_n` is 0 exactly when the free space (2^AW minus the count) is at or below the full offset.
- R4: In split timing (`tmode_sel` = 0 at reset), `near_empty_n` falls on the first read-clock edge at which `rd_ptr` makes the count at or below the offset. It rises on the first write-clock edge at which `wr_ptr` lifts the count above the offset.
- R5: In split timing, `near_full_n` falls on the first write-clock edge at which `wr_ptr` makes the free space at or below the offset. It rises on the first read-clock edge at which `rd_ptr` lifts the free space above the offset.
- R6: In single-clock timing (`tmode_sel` = 1 at reset), `near_empty_n` changes only on read-clock edges. A write that lifts the count above the offset leaves it at 0 right after that write-clock edge, and it is 1 within 6 read-clock edges.
- R7: In single-clock timing, `near_full_n` changes only on write-clock edges. A read that frees space above the offset leaves it at 0 right after that read-clock edge, and it is 1 within 6 write-clock edges.
- R8: `tmode_sel` is sampled only while `mrst_n` is low. Changing it afterwards does not change the flag timing.
- R9: A write-clock edge with `ld_en` = 1 loads the offset decoded from `ld_data`. It loads the empty offset when `ld_sel` = 0 and the full offset when `ld_sel` = 1. Without `ld_en`, both offsets hold.
- R10: The offset loaded is bits [AW-1:0] of a 32-bit value.
  - With `par_sel` = 1 at reset, that value is `{ld_data[34:27], ld_data[25:18], ld_data[16:9], ld_data[7:0]}`, and `ld_data[8]`, `ld_data[17]`, `ld_data[26]` and `ld_data[35]` are ignored.
  - With `par_sel` = 0, the value is `ld_data[31:0]`, and `ld_data[35:32]` is ignored.
- R11: `par_sel` is sampled only while `mrst_n` is low. A change afterwards does not alter how `ld_data` is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, synchronous in each domain |
| tmode_sel | input | 1 | Flag timing choice sampled at reset (0 split, 1 single-clock) |
| par_sel | input | 1 | Offset-word layout sampled at reset (1 parity lanes, 0 plain) |
| wr_ptr | input | AW+1 | Binary write pointer, write-clock domain |
| rd_ptr | input | AW+1 | Binary read pointer, read-clock domain |
| ld_en | input | 1 | Offset load strobe, write-clock domain |
| ld_sel | input | 1 | Offset target: 0 empty, 1 full |
| ld_data | input | 36 | Parallel offset word |
| near_empty_n | output | 1 | Nearly-empty flag, active low |
| near_full_n | output | 1 | Nearly-full flag, active low |

## Verification
A wrong offset or a mis-decoded parity lane does not show at once. It shows as a threshold that is off by one or by a power of two: a flag flips one word early or late in the steady state, a few cycles after the pointers settle. If a split-timing toggle pair falls out of step, a flag is stuck or inverted, and the first pointer move across the threshold shows it on the very next edge of the owning clock. A wrong mode latch makes a flag release one edge early, or three to four edges late, against the other clock.

// File: rtl/pflag_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and helpers for the threshold flag generator.
// Assumes: the offset-load word is 36 bits wide, as four 9-bit lanes.
package pflag_pkg;
    localparam int LD_W = 36;

    // Binary to gray conversion of a pointer slice.
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Gray to binary conversion by prefix xor from the top bit.
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction
endpackage

// File: rtl/pf_gray_xing.sv
`timescale 1ns/1ps
// Module: pf_gray_xing
// Moves a binary counter into another clock domain. The value is registered
// as gray code in the source domain, passed through two flops in the
// destination domain, then decoded. Assumes the source value steps by at
// most one per source cycle, or is held long enough to settle. With W = 1
// it is a plain single-bit synchronizer.
module pf_gray_xing #(
    parameter int W = 8
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [W-1:0] src_bin,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [W-1:0] dst_bin
);
    import pflag_pkg::*;

    logic [W-1:0] src_gray_q;
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    // Register the gray form so that only one bit moves per step.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) src_gray_q <= '0;
        else            src_gray_q <= W'(to_gray(32'(src_bin)));
    end

    // Two destination flops to let a metastable sample resolve.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= src_gray_q;
            sync_q <= meta_q;
        end
    end

    // Decode back to binary for arithmetic in the destination domain.
    always_comb dst_bin = W'(from_gray(32'(sync_q)));
endmodule

// File: rtl/pf_offset_load.sv
`timescale 1ns/1ps
// Module: pf_offset_load
// Holds the empty and full offsets in the write-clock domain. On reset they
// take DEF_OFS and the word layout choice is sampled. A load decodes the
// parallel word with or without the parity lanes. Assumes loads happen
// while the read side is idle, since the read domain uses the values as is.
module pf_offset_load #(
    parameter int OFS_W   = 10,
    parameter int DEF_OFS = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    par_sel,
    input  logic                    ld_en,
    input  logic                    ld_sel,
    input  logic [pflag_pkg::LD_W-1:0] ld_data,
    output logic [OFS_W-1:0]        ofs_empty,
    output logic [OFS_W-1:0]        ofs_full
);
    logic        par_q;
    logic [31:0] packed_word;

    // Sample the layout choice only while master reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) par_q <= par_sel;
    end

    // Drop the lane parity bits or take the low 32 bits as they are.
    always_comb begin
        if (par_q) packed_word = {ld_data[34:27], ld_data[25:18], ld_data[16:9], ld_data[7:0]};
        else       packed_word = ld_data[31:0];
    end

    // Offset registers, loaded one at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_empty <= OFS_W'(DEF_OFS);
            ofs_full  <= OFS_W'(DEF_OFS);
        end else if (ld_en) begin
            if (ld_sel) ofs_full  <= packed_word[OFS_W-1:0];
            else        ofs_empty <= packed_word[OFS_W-1:0];
        end
    end

    p_ofs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ld_en)) |-> ($stable(ofs_empty) && $stable(ofs_full)));

    p_par_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(par_q));
endmodule

// File: rtl/pf_async_flag.sv
`timescale 1ns/1ps
// Module: pf_async_flag
// Flag that one clock sets and another clock clears, built as a pair of
// toggle registers. The set side flips its toggle when the flag is
// inactive and set_cond holds. The clear side flips its toggle when the
// flag is active and clr_cond holds. The flag is read from the two toggles
// with no register in between. Each side sees the other's toggle through a
// two-flop synchronizer. Assumes each condition is computed from pointers
// that cross with the same latency as the toggles.
module pf_async_flag #(
    parameter bit ACT_ON_EQ = 1'b1
) (
    input  logic set_clk,
    input  logic set_rst_n,
    input  logic set_cond,
    input  logic clr_clk,
    input  logic clr_rst_n,
    input  logic clr_cond,
    output logic active
);
    logic s_tog, c_tog;
    logic c_in_set, s_in_clr;
    logic act_set, act_clr;

    pf_gray_xing #(.W(1)) u_c2s (
        .src_clk(clr_clk), .src_rst_n(clr_rst_n), .src_bin(c_tog),
        .dst_clk(set_clk), .dst_rst_n(set_rst_n), .dst_bin(c_in_set)
    );
    pf_gray_xing #(.W(1)) u_s2c (
        .src_clk(set_clk), .src_rst_n(set_rst_n), .src_bin(s_tog),
        .dst_clk(clr_clk), .dst_rst_n(clr_rst_n), .dst_bin(s_in_clr)
    );

    // Each side's own view of whether the flag is active.
    always_comb begin
        act_set = ((s_tog == c_in_set) == ACT_ON_EQ);
        act_clr = ((s_in_clr == c_tog) == ACT_ON_EQ);
        active  = ((s_tog == c_tog) == ACT_ON_EQ);
    end

    // Set side: raise the flag on this clock.
    always_ff @(posedge set_clk) begin
        if (!set_rst_n)                 s_tog <= 1'b0;
        else if (!act_set && set_cond)  s_tog <= ~s_tog;
    end

    // Clear side: drop the flag on this clock.
    always_ff @(posedge clr_clk) begin
        if (!clr_rst_n)                 c_tog <= 1'b0;
        else if (act_clr && clr_cond)   c_tog <= ~c_tog;
    end
endmodule

// File: rtl/pflag_gen.sv
`timescale 1ns/1ps
// Module: pflag_gen (top)
// Nearly-empty and nearly-full flags, both active low, for a dual-clock
// FIFO. Each domain compares its own pointer with the synchronized pointer
// of the other domain against the programmable offsets. The timing mode
// and the offset layout are sampled during master reset. Assumes mrst_n is
// held low for several edges of both clocks.
module pflag_gen #(
    parameter int AW      = 10,
    parameter int DEF_OFS = 7
) (
    input  logic                       wr_clk,
    input  logic                       rd_clk,
    input  logic                       mrst_n,
    input  logic                       tmode_sel,
    input  logic                       par_sel,
    input  logic [AW:0]                wr_ptr,
    input  logic [AW:0]                rd_ptr,
    input  logic                       ld_en,
    input  logic                       ld_sel,
    input  logic [pflag_pkg::LD_W-1:0] ld_data,
    output logic                       near_empty_n,
    output logic                       near_full_n
);
    localparam int PW    = AW + 1;
    localparam int OFS_W = AW;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0]    wp_in_rd, rp_in_wr;
    logic [PW-1:0]    cnt_rd, cnt_wr, free_rd, free_wr;
    logic [OFS_W-1:0] ofs_e, ofs_f;
    logic [PW-1:0]    ofs_e_x, ofs_f_x;
    logic             tmode_rd_q, tmode_wr_q;
    logic             ae_sync_q, af_sync_q;
    logic             ae_async, af_async;
    logic             ae_set_c, ae_clr_c, af_set_c, af_clr_c;

    pf_gray_xing #(.W(PW)) u_wp_xing (
        .src_clk(wr_clk), .src_rst_n(mrst_n), .src_bin(wr_ptr),
        .dst_clk(rd_clk), .dst_rst_n(mrst_n), .dst_bin(wp_in_rd)
    );
    pf_gray_xing #(.W(PW)) u_rp_xing (
        .src_clk(rd_clk), .src_rst_n(mrst_n), .src_bin(rd_ptr),
        .dst_clk(wr_clk), .dst_rst_n(mrst_n), .dst_bin(rp_in_wr)
    );

    pf_offset_load #(.OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_ofs (
        .clk(wr_clk), .rst_n(mrst_n), .par_sel(par_sel),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .ofs_empty(ofs_e), .ofs_full(ofs_f)
    );

    // Count and free space as seen from each domain.
    always_comb begin
        ofs_e_x  = PW'(ofs_e);
        ofs_f_x  = PW'(ofs_f);
        cnt_rd   = wp_in_rd - rd_ptr;
        cnt_wr   = wr_ptr - rp_in_wr;
        free_rd  = PW'(DEPTH) - cnt_rd;
        free_wr  = PW'(DEPTH) - cnt_wr;
        ae_set_c = (cnt_rd <= ofs_e_x);
        ae_clr_c = (cnt_wr >  ofs_e_x);
        af_set_c = (free_wr <= ofs_f_x);
        af_clr_c = (free_rd >  ofs_f_x);
    end

    // Sample the timing mode in each domain during master reset.
    always_ff @(posedge rd_clk) begin
        if (!mrst_n) tmode_rd_q <= tmode_sel;
    end

    // Same sample for the write domain.
    always_ff @(posedge wr_clk) begin
        if (!mrst_n) tmode_wr_q <= tmode_sel;
    end

    // Single-clock nearly-empty: evaluated only on the read clock.
    always_ff @(posedge rd_clk) begin
        if (!mrst_n) ae_sync_q <= 1'b1;
        else         ae_sync_q <= ae_set_c;
    end

    // Single-clock nearly-full: evaluated only on the write clock.
    always_ff @(posedge wr_clk) begin
        if (!mrst_n) af_sync_q <= 1'b0;
        else         af_sync_q <= af_set_c;
    end

    // Split timing: read sets the empty flag, write clears it.
    pf_async_flag #(.ACT_ON_EQ(1'b1)) u_ae_split (
        .set_clk(rd_clk), .set_rst_n(mrst_n), .set_cond(ae_set_c),
        .clr_clk(wr_clk), .clr_rst_n(mrst_n), .clr_cond(ae_clr_c),
        .active(ae_async)
    );
    // Split timing: write sets the full flag, read clears it.
    pf_async_flag #(.ACT_ON_EQ(1'b0)) u_af_split (
        .set_clk(wr_clk), .set_rst_n(mrst_n), .set_cond(af_set_c),
        .clr_clk(rd_clk), .clr_rst_n(mrst_n), .clr_cond(af_clr_c),
        .active(af_async)
    );

    // Select the output form from the mode sampled at reset.
    always_comb begin
        near_empty_n = tmode_rd_q ? ~ae_sync_q : ~ae_async;
        near_full_n  = tmode_wr_q ? ~af_sync_q : ~af_async;
    end

    p_rst_empty_r1: assert property (@(posedge rd_clk)
        !mrst_n |=> (near_empty_n == 1'b0));

    p_rst_full_r1: assert property (@(posedge wr_clk)
        !mrst_n |=> (near_full_n == 1'b1));

    p_tmode_rd_r8: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(tmode_rd_q));

    p_tmode_wr_r8: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(tmode_wr_q));
endmodule

// File: tb/pflag_gen_tb.sv
`timescale 1ns/1ps
// Bench for pflag_gen: directed edge-timing cases plus random steady-state checks.
module pflag_gen_tb;
    localparam int AW    = 10;
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic wr_clk = 1'b0, rd_clk = 1'b0;
    logic mrst_n = 1'b0, tmode_sel = 1'b0, par_sel = 1'b0;
    logic [PW-1:0] wr_ptr = '0, rd_ptr = '0;
    logic ld_en = 1'b0, ld_sel = 1'b0;
    logic [35:0] ld_data = '0;
    logic near_empty_n, near_full_n;

    int checks = 0, errors = 0;
    int m_ofs_e = 7, m_ofs_f = 7;
    bit m_par = 1'b0;

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz write clock
    always #3.5 rd_clk = ~rd_clk;

    pflag_gen #(.AW(AW), .DEF_OFS(7)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n),
        .tmode_sel(tmode_sel), .par_sel(par_sel),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .near_empty_n(near_empty_n), .near_full_n(near_full_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_ae(input int cnt);
        return !(cnt <= m_ofs_e);
    endfunction

    function automatic logic exp_af(input int cnt);
        return !((DEPTH - cnt) <= m_ofs_f);
    endfunction

    // Build a load word for an offset, with junk in the ignored bits.
    function automatic logic [35:0] encode(input int ofs, input bit par);
        logic [31:0] w = 32'(ofs);
        logic [35:0] d = 36'($urandom) | (36'($urandom) << 32);
        if (par) begin
            d[7:0] = w[7:0];
            d[16:9] = w[15:8];
            d[25:18] = w[23:16];
            d[34:27] = w[31:24];
        end else begin
            d[31:0] = w;
        end
        return d;
    endfunction

    task automatic do_reset(input bit tm, input bit par);
        @(negedge wr_clk);
        mrst_n = 1'b0; tmode_sel = tm; par_sel = par;
        wr_ptr = '0; rd_ptr = '0; ld_en = 1'b0;
        repeat (6) @(posedge rd_clk);
        repeat (6) @(posedge wr_clk);
        #1;
        chk("R1 empty flag in reset", near_empty_n, 1'b0);
        chk("R1 full flag in reset", near_full_n, 1'b1);
        @(negedge wr_clk);
        mrst_n = 1'b1;
        m_ofs_e = 7; m_ofs_f = 7; m_par = par;
    endtask

    task automatic settle();
        repeat (8) @(posedge rd_clk);
        repeat (8) @(posedge wr_clk);
        #1;
    endtask

    task automatic load(input bit sel, input logic [35:0] d);
        @(negedge wr_clk);
        ld_en = 1'b1; ld_sel = sel; ld_data = d;
        @(negedge wr_clk);
        ld_en = 1'b0;
    endtask

    task automatic set_ptrs(input int wp, input int rp);
        @(negedge wr_clk); wr_ptr = PW'(wp);
        @(negedge rd_clk); rd_ptr = PW'(rp);
        settle();
    endtask

    task automatic steady(input string tag, input int cnt);
        chk({tag, " R2 empty threshold"}, near_empty_n, exp_ae(cnt));
        chk({tag, " R3 full threshold"}, near_full_n, exp_af(cnt));
    endtask

    task automatic wr_step(input int wp);
        @(negedge wr_clk); wr_ptr = PW'(wp);
        @(posedge wr_clk); #1;
    endtask

    task automatic rd_step(input int rp);
        @(negedge rd_clk); rd_ptr = PW'(rp);
        @(posedge rd_clk); #1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));

        // Split timing, default offsets (R1 default value observed via threshold).
        do_reset(1'b0, 1'b0);
        set_ptrs(7, 0);   steady("R1 default offset", 7);
        set_ptrs(8, 0);   steady("R1 default offset", 8);
        // R4: read sets, write clears on the edge itself.
        set_ptrs(10, 0);
        chk("R4 start", near_empty_n, 1'b1);
        rd_step(3);  chk("R4 falls on read edge", near_empty_n, 1'b0);
        settle();
        wr_step(11); chk("R4 rises on write edge", near_empty_n, 1'b1);
        // R5: write sets, read clears.
        set_ptrs(1016, 0);
        chk("R5 start", near_full_n, 1'b1);
        wr_step(1017); chk("R5 falls on write edge", near_full_n, 1'b0);
        settle();
        rd_step(1);  chk("R5 rises on read edge", near_full_n, 1'b1);

        // R8: a later change of tmode_sel keeps split timing.
        @(negedge wr_clk); tmode_sel = 1'b1;
        set_ptrs(10, 3);
        chk("R8 start", near_empty_n, 1'b0);
        wr_step(11); chk("R8 split timing kept", near_empty_n, 1'b1);

        // Single-clock timing.
        do_reset(1'b1, 1'b0);
        set_ptrs(7, 0);
        chk("R6 start", near_empty_n, 1'b0);
        wr_step(8);  chk("R6 not released on write edge", near_empty_n, 1'b0);
        repeat (6) @(posedge rd_clk); #1;
        chk("R6 released via read clock", near_empty_n, 1'b1);
        set_ptrs(1017, 0);
        chk("R7 start", near_full_n, 1'b0);
        rd_step(1);  chk("R7 not released on read edge", near_full_n, 1'b0);
        repeat (6) @(posedge wr_clk); #1;
        chk("R7 released via write clock", near_full_n, 1'b1);

        // R10 plain layout: bit 8 counts, bits 35:32 ignored.
        do_reset(1'b0, 1'b0);
        load(1'b0, 36'hF_0000_0200);   // offset 512
        set_ptrs(512, 0); chk("R10 plain bit9 at", near_empty_n, 1'b0);
        set_ptrs(513, 0); chk("R10 plain bit9 above", near_empty_n, 1'b1);
        load(1'b0, 36'h0_0000_0100);   // offset 256
        set_ptrs(256, 0); chk("R10 plain bit8 at", near_empty_n, 1'b0);
        set_ptrs(257, 0); chk("R10 plain bit8 above", near_empty_n, 1'b1);

        // R10 parity layout: bit 8 skipped, bit 9 gives offset 256.
        do_reset(1'b0, 1'b1);
        @(negedge wr_clk); par_sel = 1'b0;           // R11: no effect now
        load(1'b0, 36'h8_0402_0300);   // parity junk, bit9 set -> 256
        set_ptrs(256, 0); chk("R10 R11 parity at", near_empty_n, 1'b0);
        set_ptrs(257, 0); chk("R10 R11 parity above", near_empty_n, 1'b1);
        // R9: full offset via ld_sel=1, empty offset untouched.
        load(1'b1, encode(100, 1'b1));
        set_ptrs(924, 0); chk("R9 full at", near_full_n, 1'b0);
        chk("R9 empty held", near_empty_n, 1'b1);
        set_ptrs(923, 0); chk("R9 full above", near_full_n, 1'b1);
        m_ofs_e = 256; m_ofs_f = 100;

        // Random steady state in both timing modes and layouts.
        for (int mode = 0; mode < 4; mode++) begin
            do_reset(mode[0], mode[1]);
            for (int it = 0; it < 30; it++) begin
                int cnt, rp;
                if (it % 6 == 0) begin
                    m_ofs_e = $urandom_range(DEPTH - 1);
                    m_ofs_f = $urandom_range(DEPTH - 1);
                    load(1'b0, encode(m_ofs_e, m_par));
                    load(1'b1, encode(m_ofs_f, m_par));
                end
                case ($urandom_range(3))
                    0: cnt = m_ofs_e + $urandom_range(2) - 1;
                    1: cnt = DEPTH - m_ofs_f + $urandom_range(2) - 1;
                    default: cnt = $urandom_range(DEPTH);
                endcase
                if (cnt < 0) cnt = 0;
                if (cnt > DEPTH) cnt = DEPTH;
                rp = $urandom_range(2 * DEPTH - 1);
                set_ptrs((rp + cnt) % (2 * DEPTH), rp);
                steady("random R9", cnt);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule